// File: doc/BRIEF.md
# Channel-Status Transmit Sequencer

This block supplies the channel-status bit that a digital audio transmitter inserts into each frame. Software loads a 192-bit status block as six 32-bit words through a simple write port. On every frame strobe from the frame formatter, while both the transmitter enable and the channel-status enable are set, the block presents the next bit of that block. Bits go out least significant first, word 0 through word 5, and the sequence then starts again at word 0.

A word is copied from its register into a shift register only when its first bit is due. Software can therefore rewrite a word while an earlier word is still going out, and the change appears on the next pass of that word. A busy flag rises when word 0 is loaded. It falls when word 5 is loaded, or at the frame boundary that follows a cleared transmitter enable. Enable changes take effect only at a frame strobe, so a frame is never cut short.

Top module: `cstx_seq`

## Requirements
- R1: While reset is asserted, and after it, cs_bit and cs_busy are 0 and all six status words hold zero.
- R2: A cycle with wr_en high and wr_idx in 0..5 stores wr_data into word wr_idx. A write with wr_idx 6 or 7 changes no word.
- R3: cs_bit and cs_busy change only in the cycle after a frame_tick. Counting enabled strobes from a block start, strobe n presents bit n mod 32 of word n div 32.
- R4: cs_busy rises at the strobe that loads word 0 with both tx_on and cs_on set. This is the first enabled strobe after idle, or the strobe after bit 191.
- R5: cs_busy falls at the strobe that loads word 5, which is strobe 160 of the block. The remaining 32 bits still go out.
- R6: After bit 191, the next enabled strobe reloads word 0 and presents its bit 0.
- R7: A word's value is taken when the word is loaded at its bit-0 strobe. A write to a word after that strobe affects only its next load.
- R8: If tx_on falls between strobes, cs_bit and cs_busy hold until the next strobe. That strobe drives both to 0, and the next enabled strobe restarts at word 0 bit 0.
- R9: A strobe with cs_on low drives cs_bit and cs_busy to 0 and does not advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_on | input | 1 | Transmitter enable |
| cs_on | input | 1 | Channel-status enable |
| frame_tick | input | 1 | One-cycle pulse at each frame start |
| wr_en | input | 1 | Word write strobe |
| wr_idx | input | IDX_W (3) | Index of the word to write |
| wr_data | input | WORD_W (32) | Word value to store |
| cs_bit | output | 1 | Channel-status bit for the current frame |
| cs_busy | output | 1 | Status-block transmission busy flag |

## Verification
The bench uses the default parameters: six 32-bit words, so one block is 192 frames. A complete block, the busy fall at strobe 160 and the wrap back to word 0 all fit in a few hundred frames. This size also leaves 3-bit indices 6 and 7 unused, which lets the bench check that writes to them are dropped. The word values are chosen so that a restart at word 0 looks different from a continuation. The latching test rewrites a word that is going out and a word that has not been loaded yet.

// File: rtl/cstx_seq.sv
module cstx_seq #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 6,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_on,
  input  logic              cs_on,
  input  logic              frame_tick,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic              cs_bit,
  output logic              cs_busy
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST_W = IDX_W'(NUM_WORDS - 1);
  localparam logic [BIT_W-1:0] LAST_B = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] words [NUM_WORDS];
  logic [WORD_W-1:0] shreg;
  logic [IDX_W-1:0]  widx;
  logic [BIT_W-1:0]  bpos;
  logic              active;

  wire sending   = tx_on && cs_on;
  wire word_end  = active && (bpos == LAST_B);
  wire block_end = word_end && (widx == LAST_W);
  wire do_load   = !active || word_end;
  wire [IDX_W-1:0]  next_w  = (!active || block_end) ? '0 : widx + IDX_W'(1);
  wire [WORD_W-1:0] fetched = words[next_w];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) words[i] <= '0;
    end else if (wr_en && int'(wr_idx) < NUM_WORDS) begin
      words[wr_idx] <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      widx    <= '0;
      bpos    <= '0;
      active  <= 1'b0;
      cs_bit  <= 1'b0;
      cs_busy <= 1'b0;
    end else if (frame_tick) begin
      if (!sending) begin
        active  <= 1'b0;
        cs_bit  <= 1'b0;
        cs_busy <= 1'b0;
      end else if (do_load) begin
        shreg  <= fetched >> 1;
        cs_bit <= fetched[0];
        widx   <= next_w;
        bpos   <= '0;
        active <= 1'b1;
        if (next_w == '0)        cs_busy <= 1'b1;
        else if (next_w == LAST_W) cs_busy <= 1'b0;
      end else begin
        shreg  <= shreg >> 1;
        cs_bit <= shreg[0];
        bpos   <= bpos + BIT_W'(1);
      end
    end
endmodule

// File: rtl/cstx_seq_chk.sv
module cstx_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_on,
  input logic cs_on,
  input logic frame_tick,
  input logic cs_bit,
  input logic cs_busy
);
  assert_reset_R1: assert property (@(posedge clk) !rst_n |=> (!cs_bit && !cs_busy));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> ($stable(cs_bit) && $stable(cs_busy)));

  assert_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_busy) |-> $past(frame_tick && tx_on && cs_on));

  assert_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_busy) |-> $past(frame_tick));

  assert_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !(tx_on && cs_on)) |=> (!cs_bit && !cs_busy));
endmodule

bind cstx_seq cstx_seq_chk i_chk (.*);

// File: tb/test_cstx_seq.sv
module test_cstx_seq;
  logic clk = 0, rst_n = 0, tx_on = 0, cs_on = 0, frame_tick = 0, wr_en = 0;
  logic [2:0]  wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic cs_bit, cs_busy;
  int n_run = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem [6];

  localparam logic [34:0] VEC [6] = '{
    {3'd0, 32'h1234_5676}, {3'd1, 32'hF0F0_0F0F}, {3'd2, 32'h8000_0001},
    {3'd3, 32'h0000_FFFF}, {3'd4, 32'hDEAD_BEEF}, {3'd5, 32'h5555_AAAA}};

  cstx_seq i_cstx_seq (.clk(clk), .rst_n(rst_n), .tx_on(tx_on), .cs_on(cs_on),
    .frame_tick(frame_tick), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cs_bit(cs_bit), .cs_busy(cs_busy));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic tick(input logic t, input logic c);
    @(negedge clk); tx_on = t; cs_on = c; frame_tick = 1;
    @(negedge clk); frame_tick = 0;
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_idx = i; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic run_frames(input int f0, input int f1, input string req);
    for (int f = f0; f <= f1; f++) begin
      tick(1, 1);
      chk(req, cs_bit, mem[f / 32][f % 32]);
      chk("R5", cs_busy, f < 160);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", cs_bit, 0);
    chk("R1", cs_busy, 0);
    rst_n = 1;
    // R1: words reset to zero, so an enabled strobe shows bit 0 = 0
    tick(1, 1);
    chk("R1", cs_bit, 0);
    chk("R4", cs_busy, 1);
    tick(0, 0);
    chk("R8", cs_busy, 0);

    for (int k = 0; k < 6; k++) begin
      wr(VEC[k][34:32], VEC[k][31:0]);
      mem[k] = VEC[k][31:0];
    end
    // R2: indices 6 and 7 are dropped
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);

    // R3 hold with no strobe
    tick(1, 1);
    chk("R3", cs_bit, mem[0][0]);
    chk("R4", cs_busy, 1);
    repeat (5) @(negedge clk);
    chk("R3", cs_bit, mem[0][0]);
    run_frames(1, 191, "R3");

    // R6 wrap, R7 latching
    tick(1, 1);
    chk("R6", cs_bit, mem[0][0]);
    chk("R6", cs_busy, 1);
    wr(3'd0, 32'h0000_0006);
    wr(3'd1, 32'h0F0F_F0F0);
    mem[1] = 32'h0F0F_F0F0;
    run_frames(1, 191, "R7");
    mem[0] = 32'h0000_0006;
    tick(1, 1);
    chk("R7", cs_bit, mem[0][0]);
    tick(1, 1);
    chk("R7", cs_bit, mem[0][1]);

    // R8 tx disable mid-frame
    @(negedge clk); tx_on = 0;
    repeat (3) @(negedge clk);
    chk("R8", cs_bit, 1);
    chk("R8", cs_busy, 1);
    tick(0, 1);
    chk("R8", cs_bit, 0);
    chk("R8", cs_busy, 0);

    // R9 cs disabled
    for (int k = 0; k < 3; k++) begin
      tick(1, 0);
      chk("R9", cs_bit, 0);
      chk("R9", cs_busy, 0);
    end
    // R8 restart at word 0 bit 0
    tick(1, 1);
    chk("R8", cs_bit, 0);
    chk("R8", cs_busy, 1);
    tick(1, 1);
    chk("R8", cs_bit, 1);
    tick(1, 1);
    chk("R8", cs_bit, 1);
    tick(1, 1);
    chk("R8", cs_bit, 0);

    // R2: a full block confirms every word, including that 6/7 writes were dropped
    tick(0, 0);
    run_frames(0, 191, "R2");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule